// File: doc/BRIEF.md
# Real-Power Pulse Rate Generator

This block turns paired voltage and current sample streams into pulse trains whose average rate follows real (active) power. Every accepted sample pair may first pass through a DC-blocking high-pass stage on each channel. The two samples are then multiplied to give instantaneous power. A first-order recursive low-pass filter extracts the mean of that product, which is the real power.

The filtered power feeds two independent energy integrators. A fast integrator drives a single high-rate output for calibration and quick readings. A slow integrator, whose energy quantum is a fixed power of two larger, drives a pair of outputs that take turns so they can step a two-phase motor or advance an electromechanical counter. A 3-bit scale input sets how much energy one pulse stands for. An active-low clear holds every filter, product and integrator at zero.

Top module: `pwr_pulse_conv`

## Requirements
- R1: With `hpf_en` = 0, each channel passes its input sample to the multiplier unchanged, so DC content reaches the power estimate.
- R2: With `hpf_en` = 1, each channel outputs y = x − (d >>> GUARD) and updates its offset state d += (y <<< GUARD) >>> HP_SHIFT. A constant input therefore decays toward zero power.
- R3: The instantaneous power p is the product of the two channel outputs. The filter state follows f += ((p <<< GUARD) − f) >>> LP_SHIFT once per sample, and the power passed on is f >>> GUARD.
- R4: When adding positive power brings an integrator to or above its threshold, that integrator emits one pulse and keeps the sum minus the threshold as its new value, so no energy is discarded.
- R5: The fast threshold is HF_BASE << `fc_sel` (`fc_sel` read as an unsigned 0..7). The slow threshold is the fast threshold << LF_SHIFT.
- R6: A filtered power of zero or below leaves both integrators unchanged and produces no pulse.
- R7: Every pulse on any output stays high for exactly PULSE_CYC clock cycles.
- R8: Slow pulses alternate between `lf_out0` and `lf_out1`, starting with `lf_out0` after a clear, and the two are never high together.
- R9: While `rst_n` is 0, all outputs are low and all filter and integrator state is zero. A run after a clear matches a run from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master clear, asynchronous |
| smp_vld | input | 1 | One-cycle strobe marking a new sample pair |
| v_smp | input | SW | Signed voltage-channel sample |
| i_smp | input | SW | Signed current-channel sample |
| hpf_en | input | 1 | 1 inserts the DC-blocking filters, 0 bypasses them |
| fc_sel | input | 3 | Energy-per-pulse scale, used as a left shift on both thresholds |
| lf_out0 | output | 1 | Slow pulse output, first phase |
| lf_out1 | output | 1 | Slow pulse output, second phase |
| hf_out | output | 1 | Fast pulse output |

## Verification
Several properties are checked on every clock cycle. In bypass, a channel output is the sample from the previous cycle. Non-positive power leaves an integrator untouched. An integrator below its threshold stays below it after adding a smaller power. A pulse never runs longer than PULSE_CYC, and the two slow outputs are never high together.

Some behaviours only show up when pulses are counted over whole runs. These are the exact pulse totals implied by the filter equations, the thresholds and the carried residue. The bench compares those totals against a model of the stated equations, for constant and square-wave inputs, with and without DC removal, at several scale settings and after a clear.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    // Which of the two slow outputs a pulse is steered to.
    typedef enum logic {
        STEP_A = 1'b0,
        STEP_B = 1'b1
    } step_phase_e;
endpackage

// File: rtl/pwr_dc_block.sv
module pwr_dc_block #(
    parameter int SW       = 16,
    parameter int GUARD    = 8,
    parameter int HP_SHIFT = 4,
    localparam int FW = SW + 1,
    localparam int DW = FW + GUARD + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 hpf_en,
    input  logic signed [SW-1:0] x,
    output logic                 out_vld,
    output logic signed [FW-1:0] y
);
    typedef struct packed {
        logic signed [DW-1:0] dc;
        logic signed [FW-1:0] y;
        logic                 vld;
    } dcb_state_t;

    dcb_state_t st_d, st_q;

    logic signed [DW-1:0] x_ext;
    logic signed [DW-1:0] dc_s;
    logic signed [DW-1:0] diff_s;
    logic signed [DW-1:0] step_s;

    always_comb begin
        st_d   = st_q;
        x_ext  = DW'(x);
        dc_s   = st_q.dc;
        diff_s = x_ext - (dc_s >>> GUARD);
        step_s = (diff_s <<< GUARD) >>> HP_SHIFT;
        st_d.vld = in_vld;
        if (in_vld) begin
            if (hpf_en) begin
                st_d.y  = FW'(diff_s);
                st_d.dc = dc_s + step_s;
            end else begin
                st_d.y  = FW'(x);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign y       = st_q.y;

    // R1: in bypass the registered output is the sample seen one cycle earlier
    p_bypass_passes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !hpf_en) |=> (out_vld && (y == FW'($past(x)))));
endmodule

// File: rtl/pwr_power_lpf.sv
module pwr_power_lpf #(
    parameter int FW       = 17,
    parameter int GUARD    = 8,
    parameter int LP_SHIFT = 6,
    localparam int PW = 2 * FW,
    localparam int AW = PW + GUARD + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [FW-1:0] a,
    input  logic signed [FW-1:0] b,
    output logic                 pwr_vld,
    output logic signed [PW-1:0] pwr
);
    typedef struct packed {
        logic signed [PW-1:0] prod;
        logic                 pvld;
        logic signed [AW-1:0] filt;
        logic                 fvld;
    } lpf_state_t;

    lpf_state_t st_d, st_q;

    logic signed [PW-1:0] mul_s;
    logic signed [PW-1:0] prod_s;
    logic signed [AW-1:0] filt_s;
    logic signed [AW-1:0] target_s;
    logic signed [AW-1:0] step_s;

    always_comb begin
        st_d     = st_q;
        mul_s    = a * b;
        prod_s   = st_q.prod;
        filt_s   = st_q.filt;
        target_s = AW'(prod_s) <<< GUARD;
        step_s   = (target_s - filt_s) >>> LP_SHIFT;
        st_d.pvld = in_vld;
        if (in_vld) st_d.prod = mul_s;
        st_d.fvld = st_q.pvld;
        if (st_q.pvld) st_d.filt = filt_s + step_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwr_vld = st_q.fvld;
    assign pwr     = PW'(filt_s >>> GUARD);

    // R3: a non-negative product cannot drive a non-negative average negative
    p_lpf_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pvld && (prod_s >= 0) && (filt_s >= 0)) |=> (st_q.filt[AW-1] == 1'b0));
    // R3: filtered power appears exactly one cycle after the product
    p_lpf_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##1 pwr_vld);
endmodule

// File: rtl/pwr_pulse_gen.sv
module pwr_pulse_gen
    import pwr_pkg::*;
#(
    parameter int PW        = 34,
    parameter int EW        = 48,
    parameter int PULSE_CYC = 4,
    parameter int NOUT      = 1,
    localparam int CW = $clog2(PULSE_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_vld,
    input  logic signed [PW-1:0] pwr,
    input  logic [EW-1:0]        th,
    output logic [NOUT-1:0]      pulse
);
    typedef struct packed {
        logic [EW-1:0] acc;
        logic [CW-1:0] cnt;
        step_phase_e   phase;
        step_phase_e   sel;
    } pg_state_t;

    pg_state_t st_d, st_q;

    logic [EW-1:0] sum;
    logic          busy;

    always_comb begin
        st_d = st_q;
        sum  = st_q.acc + $unsigned(EW'(pwr));
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (pwr_vld && (pwr > 0)) begin
            if (sum >= th) begin
                st_d.acc = sum - th;
                st_d.cnt = CW'(PULSE_CYC);
                st_d.sel = st_q.phase;
                if (NOUT > 1) st_d.phase = step_phase_e'(~st_q.phase);
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        assign pulse[k] = busy && (int'(st_q.sel) == k);
    end

    // ---------------- assertions ----------------
    logic [CW:0] hi_len_q;
    logic        vld_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q   <= '0;
            vld_seen_q <= 1'b0;
        end else begin
            vld_seen_q <= pwr_vld;
            if (!(|pulse))       hi_len_q <= '0;
            else if (vld_seen_q) hi_len_q <= (CW+1)'(1);
            else if (hi_len_q != '1) hi_len_q <= hi_len_q + 1'b1;
        end
    end

    // R7: no pulse lasts longer than the programmed width
    p_width_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len_q <= (CW+1)'(PULSE_CYC));
    // R6: non-positive power leaves the integrator untouched
    p_neg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_vld && (pwr <= 0)) |=> $stable(st_q.acc));
    // R4: residue stays below the threshold when the added power is smaller
    p_residue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_vld && (pwr >= 0) && ($unsigned(EW'(pwr)) < th) && (st_q.acc < th))
        |=> (st_q.acc < $past(th)));

    if (NOUT > 1) begin : g_alt_chk
        // R8: the two phase outputs are never high together
        p_alt_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pulse));
    end
endmodule

// File: rtl/pwr_pulse_conv.sv
module pwr_pulse_conv #(
    parameter int SW        = 16,
    parameter int GUARD     = 8,
    parameter int HP_SHIFT  = 4,
    parameter int LP_SHIFT  = 6,
    parameter int HF_BASE   = 1048576,
    parameter int LF_SHIFT  = 4,
    parameter int PULSE_CYC = 4,
    parameter int EW        = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic signed [SW-1:0] v_smp,
    input  logic signed [SW-1:0] i_smp,
    input  logic                 hpf_en,
    input  logic [2:0]           fc_sel,
    output logic                 lf_out0,
    output logic                 lf_out1,
    output logic                 hf_out
);
    localparam int FW = SW + 1;
    localparam int PW = 2 * FW;
    localparam int NCH = 2;

    logic signed [SW-1:0] ch_in  [NCH];
    logic signed [FW-1:0] ch_out [NCH];
    logic                 ch_vld [NCH];

    assign ch_in[0] = v_smp;
    assign ch_in[1] = i_smp;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwr_dc_block #(
            .SW(SW), .GUARD(GUARD), .HP_SHIFT(HP_SHIFT)
        ) u_dcb (
            .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .hpf_en(hpf_en),
            .x(ch_in[c]), .out_vld(ch_vld[c]), .y(ch_out[c])
        );
    end

    logic                 pwr_vld;
    logic signed [PW-1:0] pwr;

    pwr_power_lpf #(
        .FW(FW), .GUARD(GUARD), .LP_SHIFT(LP_SHIFT)
    ) u_lpf (
        .clk(clk), .rst_n(rst_n), .in_vld(ch_vld[0] & ch_vld[1]),
        .a(ch_out[0]), .b(ch_out[1]), .pwr_vld(pwr_vld), .pwr(pwr)
    );

    logic [EW-1:0] th_hf;
    logic [EW-1:0] th_lf;

    assign th_hf = EW'(HF_BASE) << fc_sel;
    assign th_lf = th_hf << LF_SHIFT;

    logic [0:0] hf_pulse;
    logic [1:0] lf_pulse;

    pwr_pulse_gen #(
        .PW(PW), .EW(EW), .PULSE_CYC(PULSE_CYC), .NOUT(1)
    ) u_hf (
        .clk(clk), .rst_n(rst_n), .pwr_vld(pwr_vld), .pwr(pwr),
        .th(th_hf), .pulse(hf_pulse)
    );

    pwr_pulse_gen #(
        .PW(PW), .EW(EW), .PULSE_CYC(PULSE_CYC), .NOUT(2)
    ) u_lf (
        .clk(clk), .rst_n(rst_n), .pwr_vld(pwr_vld), .pwr(pwr),
        .th(th_lf), .pulse(lf_pulse)
    );

    assign hf_out  = hf_pulse[0];
    assign lf_out0 = lf_pulse[0];
    assign lf_out1 = lf_pulse[1];

    // R5: the slow threshold always lies above the fast one
    p_th_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        th_lf > th_hf);
endmodule

// File: tb/pwr_pulse_conv_test.sv
`timescale 1ns/1ps
module pwr_pulse_conv_test;
    localparam int SW = 16, GUARD = 8, HPK = 4, LPK = 6;
    localparam int HF_BASE = 1048576, LF_SHIFT = 4, PULSE_CYC = 4;
    localparam int SPACING = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [SW-1:0] v_smp = '0, i_smp = '0;
    logic hpf_en = 1'b0;
    logic [2:0] fc_sel = 3'd0;
    logic lf_out0, lf_out1, hf_out;

    always #2 clk = ~clk;

    pwr_pulse_conv uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .v_smp(v_smp),
        .i_smp(i_smp), .hpf_en(hpf_en), .fc_sel(fc_sel),
        .lf_out0(lf_out0), .lf_out1(lf_out1), .hf_out(hf_out)
    );

    typedef struct {
        string tag;
        int    hf;
        int    lf;
    } exp_t;

    exp_t exp_q[$];
    int vectors = 0, errors = 0;
    event scn_done;
    bit  chk_busy = 1'b0;

    // monitor state
    int  hf_cnt = 0, lf_cnt = 0;
    int  run_len [3] = '{0, 0, 0};
    bit  prev_o  [3] = '{0, 0, 0};
    int  last_lf = 1;
    bit  clr_window = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: samples on the falling edge
    always @(negedge clk) begin
        bit cur [3];
        cur[0] = hf_out; cur[1] = lf_out0; cur[2] = lf_out1;
        for (int o = 0; o < 3; o++) begin
            if (cur[o]) begin
                if (!prev_o[o]) begin
                    if (o == 0) hf_cnt++;
                    else begin
                        lf_cnt++;
                        // R8: steering alternates, lf_out0 first
                        check((o - 1) == (1 - last_lf), "R8", "slow output phase",
                              o - 1, 1 - last_lf);
                        last_lf = o - 1;
                    end
                end
                run_len[o]++;
            end else begin
                if (prev_o[o] && !clr_window)
                    check(run_len[o] == PULSE_CYC, "R7", "pulse width",
                          run_len[o], PULSE_CYC);
                run_len[o] = 0;
            end
            prev_o[o] = cur[o];
        end
        if (lf_out0 && lf_out1) check(1'b0, "R8", "both slow outputs high", 1, 0);
    end

    // scoreboard consumer
    initial begin
        forever begin
            exp_t e;
            @(scn_done);
            chk_busy = 1'b1;
            e = exp_q.pop_front();
            check(hf_cnt == e.hf, e.tag, "fast pulse count", hf_cnt, e.hf);
            check(lf_cnt == e.lf, e.tag, "slow pulse count", lf_cnt, e.lf);
            chk_busy = 1'b0;
        end
    end

    // reference from the stated equations (R1-R6)
    task automatic model(input int n, input int va, input int ia, input int half,
                         input bit hpf, input int fc, output int nhf, output int nlf);
        longint dv = 0, di = 0, f = 0, ahf = 0, alf = 0;
        longint thh, thl;
        thh = longint'(HF_BASE) << fc;
        thl = thh << LF_SHIFT;
        nhf = 0; nlf = 0;
        for (int k = 0; k < n; k++) begin
            longint sg, xv, xi, yv, yi, p, pw;
            sg = (half == 0) ? 1 : (((k / half) % 2 == 0) ? 1 : -1);
            xv = sg * va; xi = sg * ia;
            if (hpf) begin
                yv = xv - (dv >>> GUARD); dv = dv + ((yv <<< GUARD) >>> HPK);
                yi = xi - (di >>> GUARD); di = di + ((yi <<< GUARD) >>> HPK);
            end else begin
                yv = xv; yi = xi;
            end
            p  = yv * yi;
            f  = f + (((p <<< GUARD) - f) >>> LPK);
            pw = f >>> GUARD;
            if (pw > 0) begin
                if (ahf + pw >= thh) begin nhf++; ahf = ahf + pw - thh; end
                else ahf = ahf + pw;
                if (alf + pw >= thl) begin nlf++; alf = alf + pw - thl; end
                else alf = alf + pw;
            end
        end
    endtask

    task automatic do_clear();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            // R9: outputs held low during clear
            check(!hf_out && !lf_out0 && !lf_out1, "R9", "outputs during clear",
                  {hf_out, lf_out0, lf_out1}, 0);
        end
        hf_cnt = 0; lf_cnt = 0; last_lf = 1;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic drive(input int k0, input int n, input int va, input int ia,
                         input int half);
        for (int k = k0; k < k0 + n; k++) begin
            int sg;
            sg = (half == 0) ? 1 : (((k / half) % 2 == 0) ? 1 : -1);
            @(posedge clk); #1;
            smp_vld = 1'b1;
            v_smp   = SW'(sg * va);
            i_smp   = SW'(sg * ia);
            @(posedge clk); #1;
            smp_vld = 1'b0;
            repeat (SPACING - 2) @(posedge clk);
        end
    endtask

    task automatic run_scn(input string tag, input int n, input int va, input int ia,
                           input int half, input bit hpf, input int fc);
        exp_t e;
        int nh, nl;
        hpf_en = hpf;
        fc_sel = 3'(fc);
        do_clear();
        model(n, va, ia, half, hpf, fc, nh, nl);
        e.tag = tag; e.hf = nh; e.lf = nl;
        exp_q.push_back(e);
        drive(0, n, va, ia, half);
        repeat (40) @(posedge clk);
        #1;
        -> scn_done;
        #1;
        wait (!chk_busy);
    endtask

    initial begin
        int nh, nl;
        #1;
        @(negedge clk);
        // R9: reset state
        check(!hf_out && !lf_out0 && !lf_out1, "R9", "outputs at reset",
              {hf_out, lf_out0, lf_out1}, 0);
        @(posedge clk); #1; rst_n = 1'b1;

        run_scn("R1", 600, 600, 500, 0, 1'b0, 0);   // R1 R3 R4: DC passes, exact totals
        run_scn("R5", 600, 600, 500, 0, 1'b0, 2);   // R5: larger energy per pulse
        run_scn("R2", 400, 600, 500, 0, 1'b1, 0);   // R2: DC removed
        run_scn("R3", 600, 600, 500, 10, 1'b0, 0);  // R3: in-phase square wave
        run_scn("R2", 600, 600, 500, 25, 1'b1, 1);  // R2: AC through the filters
        run_scn("R6", 400, 600, -500, 0, 1'b0, 0);  // R6: negative power
        model(400, 600, -500, 0, 1'b0, 0, nh, nl);
        check(nh == 0 && nl == 0, "R6", "model pulses for negative power", nh + nl, 0);

        // R9: clear in the middle of a pulse, then a fresh run must match
        hpf_en = 1'b0; fc_sel = 3'd0;
        do_clear();
        fork
            drive(0, 200, 600, 500, 0);
            begin
                wait (hf_out == 1'b1);
                #1;
                clr_window = 1'b1;
            end
        join
        do_clear();
        repeat (8) @(posedge clk);
        clr_window = 1'b0;
        run_scn("R9", 600, 600, 500, 0, 1'b0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule